// File: doc/BRIEF.md
# Packed-Word Palette Loader

This block holds a 256-entry colour lookup table. Each entry is 24 bits: an 8-bit red, an 8-bit green and an 8-bit blue component. A host loads the table through two write strobes. The first, the group-select strobe, carries an entry index and points the loader at a group of four consecutive entries. The second, the word strobe, delivers one 32-bit word. A group of four entries is 12 bytes, so three words fill it. Each word carries four bytes of one continuous red-green-blue byte stream, which means entry boundaries do not line up with word boundaries. The loader holds the bytes that are left over from one word until the rest of that entry arrives in the next word.

When the third word of a group has been taken, the loader moves on to the next group of four by itself. A host can therefore stream any number of groups after a single group-select write. The table is read through a lookup port. A pixel index is presented with a valid flag, and the 24-bit colour appears one cycle later together with its own valid flag. Host writes never stall lookups.

Neither write strobe has a ready signal. The loader accepts one strobe of each kind in every cycle and never applies back-pressure. The lookup port also accepts a request in every cycle, and each request is answered exactly one cycle later.

Top module: `pal_loader`

## Requirements
- R1: After reset, `lk_color_valid` is low, and the group pointer and word position are both zero. Words written before any group-select write therefore fill entries 0 to 3.
- R2: A group-select write sets the group base to `grp_idx` with its two low bits forced to zero. The two low bits of `grp_idx` have no effect.
- R3: Bytes are taken from each word most significant byte first, forming one stream per group. Word 0 holds [31:24]=e0.R, [23:16]=e0.G, [15:8]=e0.B, [7:0]=e1.R. Word 1 holds [31:24]=e1.G, [23:16]=e1.B, [15:8]=e2.R, [7:0]=e2.G. Word 2 holds [31:24]=e2.B, [23:16]=e3.R, [15:8]=e3.G, [7:0]=e3.B. Here eN is entry base+N. A looked-up colour is {R,G,B}, with R in bits [23:16] and B in bits [7:0].
- R4: An entry is written only when all three of its bytes have arrived. After one word of a group, only e0 changes. After two words, only e0 and e1 change. The remaining entries keep their old contents.
- R5: Taking the third word of a group advances the base by 4 and returns the word position to word 0, so groups can be streamed back to back.
- R6: Advancing past the group at index 252 wraps the base to index 0.
- R7: A group-select write in the middle of a group restarts the word position at word 0 and discards the held leftover bytes. The entry that was waiting for those bytes is not written.
- R8: If the group-select strobe and the word strobe are high in the same cycle, the group select takes effect and that word is dropped without writing anything.
- R9: `lk_color_valid` is high in exactly the cycles that follow a cycle with `lk_valid` high.
- R10: A lookup in the same cycle as a write to the same entry returns the entry's previous contents. The following lookup returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_we | input | 1 | Group-select strobe |
| grp_idx | input | 8 | Entry index for the group select (low two bits ignored) |
| word_we | input | 1 | Packed colour word strobe |
| word_data | input | 32 | Packed colour word, most significant byte first |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | 8 | Pixel index to look up |
| lk_color_valid | output | 1 | Lookup result valid, one cycle after the request |
| lk_color | output | 24 | Looked-up colour {R,G,B} |

## Verification
A table of vectors loads full groups and groups cut short after zero, one or two words. Some vectors use indices with nonzero low bits. Each entry of the group is then compared against a reference model. Full groups pin down the byte positions, and partial groups separate entry-at-a-time commits from word-at-a-time commits. Separate directed tests cover three more cases:
- Long streams with no group-select write in between: one across the 252-to-0 wrap, and one that fills the whole table, which exercise the auto-advance.
- A group-select write in the middle of a group, and a group-select write in the same cycle as a word, which show whether leftover bytes or a dropped word leak into the table.
- A lookup that coincides with a write to the same entry, which tells old-data returns apart from new-data returns.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Entries per group, which is also the number of bytes per host word.
  localparam int LANES = 4;

  // Position of the next word within the current group.
  typedef enum logic [1:0] {
    PH_W0 = 2'd0,
    PH_W1 = 2'd1,
    PH_W2 = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_bank.sv
// One quarter of the table: the entries whose index ends in the same two bits.
module pal_bank #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // The read samples the array before this cycle's write lands.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_word_seq.sv
// Unpacks host words into bank writes and keeps the group pointer.
module pal_word_seq
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  localparam int GRP_W   = IDX_W - 2,
  localparam int ENTRY_W = 3 * COMP_W,
  localparam int WORD_W  = LANES * COMP_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          grp_we,
  input  logic [IDX_W-1:0]              grp_idx,
  input  logic                          word_we,
  input  logic [WORD_W-1:0]             word_data,
  output logic [GRP_W-1:0]              grp_o,
  output logic [LANES-1:0]              bank_we,
  output logic [LANES-1:0][ENTRY_W-1:0] bank_wdata
);
  phase_e              ph_q;
  logic [GRP_W-1:0]    grp_q;
  logic [COMP_W-1:0]   hold_a_q, hold_b_q;
  logic [COMP_W-1:0]   byte_at [LANES];
  logic                take_word;

  // A group select in the same cycle drops the word (R8).
  assign take_word = word_we & ~grp_we;
  assign grp_o     = grp_q;

  // Byte 0 of the stream is the most significant byte of the word.
  for (genvar k = 0; k < LANES; k++) begin : g_bytes
    assign byte_at[k] = word_data[WORD_W-1-k*COMP_W -: COMP_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_W0;
      grp_q    <= '0;
      hold_a_q <= '0;
      hold_b_q <= '0;
    end else if (grp_we) begin
      // The two low index bits are discarded (R2); a restart clears the word position (R7).
      ph_q  <= PH_W0;
      grp_q <= grp_idx[IDX_W-1:2];
    end else if (take_word) begin
      unique case (ph_q)
        PH_W0: begin
          hold_a_q <= byte_at[3];
          ph_q     <= PH_W1;
        end
        PH_W1: begin
          hold_a_q <= byte_at[2];
          hold_b_q <= byte_at[3];
          ph_q     <= PH_W2;
        end
        PH_W2: begin
          ph_q  <= PH_W0;
          grp_q <= grp_q + GRP_W'(1);
        end
        default: ph_q <= PH_W0;
      endcase
    end
  end

  // A bank is written only once all three bytes of its entry are present (R4).
  always_comb begin
    bank_we    = '0;
    bank_wdata = '0;
    if (take_word) begin
      unique case (ph_q)
        PH_W0: begin
          bank_we[0]    = 1'b1;
          bank_wdata[0] = {byte_at[0], byte_at[1], byte_at[2]};
        end
        PH_W1: begin
          bank_we[1]    = 1'b1;
          bank_wdata[1] = {hold_a_q, byte_at[0], byte_at[1]};
        end
        PH_W2: begin
          bank_we[2]    = 1'b1;
          bank_wdata[2] = {hold_a_q, hold_b_q, byte_at[0]};
          bank_we[3]    = 1'b1;
          bank_wdata[3] = {byte_at[1], byte_at[2], byte_at[3]};
        end
        default: ;
      endcase
    end
  end

  assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);

  assert_select_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_we |=> (ph_q == PH_W0) && (grp_q == $past(grp_idx[IDX_W-1:2])));

  assert_group_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !grp_we && ph_q == PH_W2) |=> grp_q == $past(grp_q) + GRP_W'(1));

  assert_select_drops_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_we |-> bank_we == '0);

  assert_word_commits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !grp_we) |-> ($countones(bank_we) >= 1 && $countones(bank_we) <= 2));
endmodule

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grp_we,
  input  logic [IDX_W-1:0]      grp_idx,
  input  logic                  word_we,
  input  logic [4*COMP_W-1:0]   word_data,
  input  logic                  lk_valid,
  input  logic [IDX_W-1:0]      lk_idx,
  output logic                  lk_color_valid,
  output logic [3*COMP_W-1:0]   lk_color
);
  localparam int GRP_W      = IDX_W - 2;
  localparam int BANK_DEPTH = 1 << GRP_W;
  localparam int ENTRY_W    = 3 * COMP_W;

  logic [GRP_W-1:0]              grp;
  logic [LANES-1:0]              bank_we;
  logic [LANES-1:0][ENTRY_W-1:0] bank_wdata;
  logic [LANES-1:0][ENTRY_W-1:0] bank_rdata;
  logic [1:0]                    sel_q;
  logic                          vld_q;

  pal_word_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_we     (grp_we),
    .grp_idx    (grp_idx),
    .word_we    (word_we),
    .word_data  (word_data),
    .grp_o      (grp),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata)
  );

  // One bank per entry slot, so the two commits of the last word never collide.
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    pal_bank #(.DEPTH(BANK_DEPTH), .AW(GRP_W), .DW(ENTRY_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .waddr (grp),
      .wdata (bank_wdata[g]),
      .re    (lk_valid),
      .raddr (lk_idx[IDX_W-1:2]),
      .rdata (bank_rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= '0;
    end else begin
      vld_q <= lk_valid;
      if (lk_valid) sel_q <= lk_idx[1:0];
    end
  end

  assign lk_color_valid = vld_q;
  assign lk_color       = bank_rdata[sel_q];

  assert_lookup_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_color_valid);

  assert_lookup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_color_valid);
endmodule

// File: tb/pal_loader_test.sv
module pal_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        grp_we, word_we, lk_valid;
  logic [7:0]  grp_idx, lk_idx;
  logic [31:0] word_data;
  logic        lk_color_valid;
  logic [23:0] lk_color;

  int tests = 0;
  int fails = 0;

  logic [23:0] ref_mem   [256];
  bit          ref_known [256];

  always #5 clk = ~clk;

  pal_loader uut (
    .clk(clk), .rst_n(rst_n), .grp_we(grp_we), .grp_idx(grp_idx),
    .word_we(word_we), .word_data(word_data), .lk_valid(lk_valid),
    .lk_idx(lk_idx), .lk_color_valid(lk_color_valid), .lk_color(lk_color)
  );

  // Vector layout: {index[8], words[2], w0[32], w1[32], w2[32]}
  localparam logic [105:0] VECS [6] = '{
    {8'h10, 2'd3, 32'h11223344, 32'h55667788, 32'h99AABBCC},
    {8'h12, 2'd1, 32'hA1A2A3A4, 32'h00000000, 32'h00000000},
    {8'h13, 2'd2, 32'hB1B2B3B4, 32'hC1C2C3C4, 32'h00000000},
    {8'h27, 2'd3, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF},
    {8'h25, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {8'hFE, 2'd3, 32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4}
  };

  function automatic logic [31:0] mk(input int g, input int w);
    return (32'(g) * 32'h01000193 + 32'(w) * 32'h9E3779B9) ^ 32'h5A5AA5A5;
  endfunction

  task automatic chk(input string req, input string what, input logic [23:0] got, input logic [23:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference model: bytes form one MSB-first stream; an entry is updated once its three bytes exist.
  task automatic apply_ref(input int base, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input int nw);
    logic [7:0] s [12];
    for (int k = 0; k < 4; k++) begin
      s[k]     = w0[31-8*k -: 8];
      s[4 + k] = w1[31-8*k -: 8];
      s[8 + k] = w2[31-8*k -: 8];
    end
    for (int e = 0; e < 4; e++) begin
      if ((e + 1) * 3 <= 4 * nw) begin
        ref_mem[(base + e) % 256]   = {s[3*e], s[3*e+1], s[3*e+2]};
        ref_known[(base + e) % 256] = 1'b1;
      end
    end
  endtask

  task automatic put_grp(input logic [7:0] idx);
    @(negedge clk); grp_we = 1'b1; grp_idx = idx;
    @(posedge clk); #1 grp_we = 1'b0;
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk); word_we = 1'b1; word_data = w;
    @(posedge clk); #1 word_we = 1'b0;
  endtask

  task automatic lookup(input int idx, output logic [23:0] col, output logic vld);
    @(negedge clk); lk_valid = 1'b1; lk_idx = idx[7:0];
    @(posedge clk); #1 lk_valid = 1'b0;
    @(negedge clk); col = lk_color; vld = lk_color_valid;
  endtask

  task automatic check_entry(input int idx, input string req);
    logic [23:0] col;
    logic        vld;
    lookup(idx, col, vld);
    if (ref_known[idx % 256]) chk(req, $sformatf("entry %0d", idx % 256), col, ref_mem[idx % 256]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] col, old_col;
    logic        vld;
    for (int i = 0; i < 256; i++) begin ref_known[i] = 1'b0; ref_mem[i] = '0; end
    grp_we = 0; word_we = 0; lk_valid = 0; grp_idx = 0; lk_idx = 0; word_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "lookup valid in reset", {23'd0, lk_color_valid}, 24'd0);
    rst_n = 1'b1;

    // R1: words with no group select land in group 0
    put_word(32'hC0FFEE12); put_word(32'h3456789A); put_word(32'hBCDEF012);
    apply_ref(0, 32'hC0FFEE12, 32'h3456789A, 32'hBCDEF012, 3);
    for (int e = 0; e < 4; e++) check_entry(e, "R1");

    // Table walk: R2 index masking, R3 packing, R4 partial groups
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  vi;
      int          vn;
      logic [31:0] a, b, c;
      vi = VECS[v][105:98]; vn = int'(VECS[v][97:96]);
      a = VECS[v][95:64]; b = VECS[v][63:32]; c = VECS[v][31:0];
      put_grp(vi);
      if (vn > 0) put_word(a);
      if (vn > 1) put_word(b);
      if (vn > 2) put_word(c);
      apply_ref(int'(vi) & 32'hFC, a, b, c, vn);
      for (int e = 0; e < 4; e++)
        check_entry((int'(vi) & 32'hFC) + e, vn == 3 ? "R3" : (vn == 0 ? "R2" : "R4"));
    end

    // R7: a mid-group select discards the held byte and restarts at word 0
    put_grp(8'h30);
    put_word(32'h10203040);
    apply_ref(8'h30, 32'h10203040, 0, 0, 1);
    put_grp(8'h30);
    put_word(32'hE1E2E3E4); put_word(32'hF1F2F3F4); put_word(32'hA5B6C7D8);
    apply_ref(8'h30, 32'hE1E2E3E4, 32'hF1F2F3F4, 32'hA5B6C7D8, 3);
    for (int e = 0; e < 4; e++) check_entry(8'h30 + e, "R7");

    // R8: a word in the same cycle as a group select is dropped
    @(negedge clk); grp_we = 1'b1; grp_idx = 8'h40; word_we = 1'b1; word_data = 32'h66666666;
    @(posedge clk); #1 begin grp_we = 1'b0; word_we = 1'b0; end
    put_word(32'h13579BDF); put_word(32'h2468ACE0); put_word(32'h0A0B0C0D);
    apply_ref(8'h40, 32'h13579BDF, 32'h2468ACE0, 32'h0A0B0C0D, 3);
    for (int e = 0; e < 4; e++) check_entry(8'h40 + e, "R8");

    // R5 and R6: stream three groups from 248 across the wrap to 0
    put_grp(8'hF8);
    for (int g = 0; g < 3; g++) begin
      for (int w = 0; w < 3; w++) put_word(mk(g + 300, w));
      apply_ref(248 + 4 * g, mk(g + 300, 0), mk(g + 300, 1), mk(g + 300, 2), 3);
    end
    for (int e = 248; e < 256; e++) check_entry(e, "R5");
    for (int e = 0; e < 4; e++) check_entry(e, "R6");

    // R9 and R10: a lookup during the write of the same entry sees the old value
    put_grp(8'h50);
    put_word(mk(7, 0)); put_word(mk(7, 1)); put_word(mk(7, 2));
    apply_ref(8'h50, mk(7, 0), mk(7, 1), mk(7, 2), 3);
    old_col = ref_mem[8'h52];
    put_grp(8'h50);
    put_word(mk(8, 0)); put_word(mk(8, 1));
    @(negedge clk); word_we = 1'b1; word_data = mk(8, 2); lk_valid = 1'b1; lk_idx = 8'h52;
    @(posedge clk); #1 begin word_we = 1'b0; lk_valid = 1'b0; end
    @(negedge clk);
    chk("R10", "lookup during write", lk_color, old_col);
    chk("R9", "valid one cycle after request", {23'd0, lk_color_valid}, 24'd1);
    @(negedge clk);
    chk("R9", "valid after idle cycle", {23'd0, lk_color_valid}, 24'd0);
    apply_ref(8'h50, mk(8, 0), mk(8, 1), mk(8, 2), 3);
    check_entry(8'h52, "R10");

    // R3 and R5: fill the whole table from one group select
    put_grp(8'h00);
    for (int g = 0; g < 64; g++) begin
      for (int w = 0; w < 3; w++) put_word(mk(g, w));
      apply_ref(4 * g, mk(g, 0), mk(g, 1), mk(g, 2), 3);
    end
    for (int e = 0; e < 256; e++) check_entry(e, "R5");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule